// File: doc/BRIEF.md
# NAND Read-Retry Parameter Sequencer

This block programs the read-retry parameter registers of a NAND flash die through a simple typed cycle bus. A host pulses `start` with a job select. The apply job opens a parameter session with command 0x36, writes one row of retry values from a table held inside the block, and closes the session with command 0x16. The table-read job puts the die into its one-time-programmable area, reads the retry table page, and then restores normal operation and ends with a dummy read.

The bus side is valid/ready. While `bus_valid` is high, the cycle descriptor (`bus_kind`, `bus_byte`, `bus_page`, `bus_len`) is held unchanged until the cycle in which `bus_ready` is high. That cycle is the acknowledge. `bus_fail`, sampled together with that acknowledge, marks the step as failed. The bus may hold `bus_ready` low for as long as it needs. The block stalls and never drops or changes a pending cycle. Pin timing, ECC and storage of the page data belong to the bus agent.

Top module: `nand_retry_seq`

## Requirements
- R1: An accepted apply job issues a command cycle (kind 0) with byte 0x36, then NREGS register pairs, then a command cycle with byte 0x16, which is its last cycle. That makes 2*NREGS+2 cycles in total. Kind codes are CMD=0, ADDR=1, DOUT=2, RESET=3, PAGE_READ=4.
- R2: Register pair r (r = 0 first) is one ADDR cycle followed by one DOUT cycle. The ADDR cycle carries the r-th register number of the list 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF. The DOUT cycle carries table entry k = mode*NREGS + r, where entry k holds (k mod 256) XOR 0xA5.
- R3: The table-read job first issues RESET, CMD 0x36, ADDR 0x38, DOUT 0x52, CMD 0x16, CMD 0x17, CMD 0x04 and CMD 0x19. It then issues PAGE_READ with the page and length latched at start. `bus_page` and `bus_len` are zero on every other cycle, and `bus_byte` is zero on RESET and PAGE_READ cycles.
- R4: After that page read, the table-read job issues RESET, CMD 0x36, ADDR 0x38, DOUT 0x00, CMD 0x16, and finally PAGE_READ with page 0 and length 0. The job has 15 cycles in total.
- R5: An acknowledge with `bus_fail` high ends the job at once. In the next cycle `err` pulses for one cycle and `busy` and `bus_valid` are low, and no further cycle is issued.
- R6: While `bus_valid` is high and `bus_ready` is low, the descriptor stays the same and the job does not advance.
- R7: An apply start whose mode index is at or above `cfg_modes`, or at or above NUM_MODES, is rejected. `err` pulses in the next cycle and no bus cycle is issued. The mode index is not checked for the table-read job.
- R8: A `start` pulse while `busy` is high is ignored, and the running job goes on unchanged.
- R9: `busy` rises in the cycle after an accepted start and stays high until the final acknowledge. In the next cycle `busy` falls and `done` pulses for one cycle. `done` and `err` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse for a job |
| job_sel | input | 1 | 0 = apply retry mode, 1 = read retry table page |
| mode_idx | input | MODE_W | Retry mode for the apply job |
| cfg_modes | input | MODE_W | Number of modes currently allowed |
| otp_page | input | PAGE_W | Page to read in the table-read job |
| otp_len | input | LEN_W | Byte count of that page read |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle pulse when a job completes |
| err | output | 1 | One-cycle pulse on reject or on a failed step |
| bus_valid | output | 1 | A bus cycle is pending |
| bus_ready | input | 1 | The bus accepts the pending cycle |
| bus_fail | input | 1 | The accepted cycle failed (valid with bus_ready) |
| bus_kind | output | 3 | Cycle kind code |
| bus_byte | output | 8 | Command, register number or data byte |
| bus_page | output | PAGE_W | Page number for PAGE_READ |
| bus_len | output | LEN_W | Byte count for PAGE_READ |

## Verification
The bench holds `bus_ready` low on every other cycle. A design that advanced or changed the descriptor under back-pressure would show a skipped or altered step. It injects failures on the first step, on a middle data step, on the table page read and on the final dummy read. A sequencer that went on after a failure, or that raised `done`, would be caught by the cycle count and the pulse checks. It tests mode indices just below and at `cfg_modes`, and above NUM_MODES. An off-by-one in the limit would start a job it should have rejected, or reject the last legal mode. It also pulses `start` with the other job selected in the middle of a run, which would change the running sequence if the block accepted that pulse.

// File: rtl/nrr_pkg.sv
package nrr_pkg;

  typedef enum logic [2:0] {
    K_CMD   = 3'd0,
    K_ADDR  = 3'd1,
    K_DOUT  = 3'd2,
    K_RESET = 3'd3,
    K_PREAD = 3'd4
  } kind_e;

  typedef enum logic {
    JOB_APPLY = 1'b0,
    JOB_OTP   = 1'b1
  } job_e;

  localparam logic [7:0] OP_OPEN   = 8'h36;
  localparam logic [7:0] OP_CLOSE  = 8'h16;
  localparam logic [7:0] OP_UNLK_A = 8'h17;
  localparam logic [7:0] OP_UNLK_B = 8'h04;
  localparam logic [7:0] OP_UNLK_C = 8'h19;
  localparam logic [7:0] GATE_REG  = 8'h38;
  localparam logic [7:0] GATE_ON   = 8'h52;
  localparam logic [7:0] GATE_OFF  = 8'h00;

  localparam int MAX_REGS = 8;
  localparam logic [7:0] RETRY_REG [MAX_REGS] =
    '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};

  localparam int OTP_STEPS = 15;

  function automatic logic [7:0] tab_val(input int k);
    return 8'(k) ^ 8'hA5;
  endfunction

endpackage

// File: rtl/nrr_value_rom.sv
module nrr_value_rom #(
  parameter int NUM_MODES = 10,
  parameter int NREGS     = 8,
  parameter int MODE_W    = 4,
  parameter int RI_W      = 3
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [RI_W-1:0]   reg_idx,
  output logic [7:0]        val
);
  import nrr_pkg::*;

  localparam int DEPTH = NUM_MODES * NREGS;
  localparam int IDX_W = $clog2(DEPTH) + 1;

  logic [7:0]       tab [DEPTH];
  logic [IDX_W-1:0] idx;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tab
    assign tab[k] = tab_val(k);
  end

  assign idx = IDX_W'(mode) * IDX_W'(NREGS) + IDX_W'(reg_idx);
  assign val = (int'(idx) < DEPTH) ? tab[idx] : 8'h00;

endmodule

// File: rtl/nrr_step_gen.sv
module nrr_step_gen #(
  parameter int NUM_MODES = 10,
  parameter int NREGS     = 8,
  parameter int MODE_W    = 4,
  parameter int PAGE_W    = 24,
  parameter int LEN_W     = 16,
  parameter int STEP_W    = 5
) (
  input  nrr_pkg::job_e      job,
  input  logic [STEP_W-1:0]  step,
  input  logic [MODE_W-1:0]  mode,
  input  logic [PAGE_W-1:0]  page_q,
  input  logic [LEN_W-1:0]   len_q,
  output nrr_pkg::kind_e     kind,
  output logic [7:0]         byte_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [LEN_W-1:0]   len_o,
  output logic               last
);
  import nrr_pkg::*;

  localparam int RI_W     = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam int APPLY_LAST = 2 * NREGS + 1;

  logic [STEP_W-1:0] stm1;
  logic [RI_W-1:0]   reg_idx;
  logic [7:0]        tab_byte;

  assign stm1    = step - 1'b1;
  assign reg_idx = RI_W'(stm1 >> 1);

  nrr_value_rom #(
    .NUM_MODES(NUM_MODES), .NREGS(NREGS), .MODE_W(MODE_W), .RI_W(RI_W)
  ) u_rom (
    .mode(mode), .reg_idx(reg_idx), .val(tab_byte)
  );

  always_comb begin
    kind   = K_CMD;
    byte_o = 8'h00;
    page_o = '0;
    len_o  = '0;
    last   = 1'b0;
    if (job == JOB_APPLY) begin
      if (int'(step) == 0) begin
        byte_o = OP_OPEN;
      end else if (int'(step) == APPLY_LAST) begin
        byte_o = OP_CLOSE;
        last   = 1'b1;
      end else if (stm1[0] == 1'b0) begin
        kind   = K_ADDR;
        byte_o = RETRY_REG[reg_idx];
      end else begin
        kind   = K_DOUT;
        byte_o = tab_byte;
      end
    end else begin
      case (int'(step))
        0:  kind = K_RESET;
        1:  byte_o = OP_OPEN;
        2:  begin kind = K_ADDR; byte_o = GATE_REG; end
        3:  begin kind = K_DOUT; byte_o = GATE_ON;  end
        4:  byte_o = OP_CLOSE;
        5:  byte_o = OP_UNLK_A;
        6:  byte_o = OP_UNLK_B;
        7:  byte_o = OP_UNLK_C;
        8:  begin kind = K_PREAD; page_o = page_q; len_o = len_q; end
        9:  kind = K_RESET;
        10: byte_o = OP_OPEN;
        11: begin kind = K_ADDR; byte_o = GATE_REG; end
        12: begin kind = K_DOUT; byte_o = GATE_OFF; end
        13: byte_o = OP_CLOSE;
        default: begin kind = K_PREAD; last = 1'b1; end
      endcase
    end
  end

endmodule

// File: rtl/nrr_ctrl.sv
module nrr_ctrl #(
  parameter int NUM_MODES = 10,
  parameter int MODE_W    = 4,
  parameter int PAGE_W    = 24,
  parameter int LEN_W     = 16,
  parameter int STEP_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               job_sel,
  input  logic [MODE_W-1:0]  mode_idx,
  input  logic [MODE_W-1:0]  cfg_modes,
  input  logic [PAGE_W-1:0]  otp_page,
  input  logic [LEN_W-1:0]   otp_len,
  input  logic               bus_ready,
  input  logic               bus_fail,
  input  logic               last,
  output logic               busy,
  output logic               done,
  output logic               err,
  output nrr_pkg::job_e      job_q,
  output logic [MODE_W-1:0]  mode_q,
  output logic [PAGE_W-1:0]  page_q,
  output logic [LEN_W-1:0]   len_q,
  output logic [STEP_W-1:0]  step_q
);
  import nrr_pkg::*;

  logic bad_mode;

  assign bad_mode = (job_sel == 1'b0) &&
                    ((int'(mode_idx) >= int'(cfg_modes)) || (int'(mode_idx) >= NUM_MODES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      job_q  <= JOB_APPLY;
      mode_q <= '0;
      page_q <= '0;
      len_q  <= '0;
      step_q <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (bad_mode) begin
            err <= 1'b1;
          end else begin
            busy   <= 1'b1;
            step_q <= '0;
            job_q  <= job_e'(job_sel);
            mode_q <= mode_idx;
            page_q <= otp_page;
            len_q  <= otp_len;
          end
        end
      end else if (bus_ready) begin
        if (bus_fail) begin
          busy <= 1'b0;
          err  <= 1'b1;
        end else if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  AST_FAIL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_ready && bus_fail |=> err && !busy); // R5

  AST_REJECT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !job_sel && (int'(mode_idx) >= int'(cfg_modes)) |=> err && !busy); // R7

  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !bus_ready |=> busy && $stable(step_q) && $stable(job_q)); // R8

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R9

  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done || err); // R9

endmodule

// File: rtl/nand_retry_seq.sv
module nand_retry_seq #(
  parameter int NUM_MODES = 10,
  parameter int NREGS     = 8,
  parameter int MODE_W    = 4,
  parameter int PAGE_W    = 24,
  parameter int LEN_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              job_sel,
  input  logic [MODE_W-1:0] mode_idx,
  input  logic [MODE_W-1:0] cfg_modes,
  input  logic [PAGE_W-1:0] otp_page,
  input  logic [LEN_W-1:0]  otp_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              bus_valid,
  input  logic              bus_ready,
  input  logic              bus_fail,
  output logic [2:0]        bus_kind,
  output logic [7:0]        bus_byte,
  output logic [PAGE_W-1:0] bus_page,
  output logic [LEN_W-1:0]  bus_len
);
  import nrr_pkg::*;

  localparam int MAX_STEP = (2 * NREGS + 2 > OTP_STEPS) ? 2 * NREGS + 2 : OTP_STEPS;
  localparam int STEP_W   = $clog2(MAX_STEP + 1);

  job_e              job_q;
  kind_e             kind;
  logic [MODE_W-1:0] mode_q;
  logic [PAGE_W-1:0] page_q;
  logic [LEN_W-1:0]  len_q;
  logic [STEP_W-1:0] step_q;
  logic              last;

  nrr_ctrl #(
    .NUM_MODES(NUM_MODES), .MODE_W(MODE_W), .PAGE_W(PAGE_W),
    .LEN_W(LEN_W), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .job_sel(job_sel),
    .mode_idx(mode_idx), .cfg_modes(cfg_modes), .otp_page(otp_page),
    .otp_len(otp_len), .bus_ready(bus_ready), .bus_fail(bus_fail),
    .last(last), .busy(busy), .done(done), .err(err), .job_q(job_q),
    .mode_q(mode_q), .page_q(page_q), .len_q(len_q), .step_q(step_q)
  );

  nrr_step_gen #(
    .NUM_MODES(NUM_MODES), .NREGS(NREGS), .MODE_W(MODE_W),
    .PAGE_W(PAGE_W), .LEN_W(LEN_W), .STEP_W(STEP_W)
  ) u_steps (
    .job(job_q), .step(step_q), .mode(mode_q), .page_q(page_q),
    .len_q(len_q), .kind(kind), .byte_o(bus_byte), .page_o(bus_page),
    .len_o(bus_len), .last(last)
  );

  assign bus_valid = busy;
  assign bus_kind  = kind;

  AST_HOLD_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_kind) && $stable(bus_byte)
      && $stable(bus_page) && $stable(bus_len)); // R6

endmodule

// File: tb/nand_retry_seq_tb_top.sv
module nand_retry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        job_sel = 1'b0;
  logic [3:0]  mode_idx = '0;
  logic [3:0]  cfg_modes = '0;
  logic [23:0] otp_page = '0;
  logic [15:0] otp_len = '0;
  logic        bus_ready = 1'b0;
  logic        bus_fail = 1'b0;
  logic        busy, done, err, bus_valid;
  logic [2:0]  bus_kind;
  logic [7:0]  bus_byte;
  logic [23:0] bus_page;
  logic [15:0] bus_len;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nand_retry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .job_sel(job_sel),
    .mode_idx(mode_idx), .cfg_modes(cfg_modes), .otp_page(otp_page),
    .otp_len(otp_len), .busy(busy), .done(done), .err(err),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_fail(bus_fail),
    .bus_kind(bus_kind), .bus_byte(bus_byte), .bus_page(bus_page),
    .bus_len(bus_len)
  );

  // vector: {job, page_sel, mode[3:0], cfg[3:0], stall, poke, fail_at[5:0]}, 63 = no failure
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd0,  4'd10, 1'b0, 1'b0, 6'd63},
    {1'b0, 1'b0, 4'd3,  4'd10, 1'b1, 1'b1, 6'd63},
    {1'b0, 1'b0, 4'd9,  4'd10, 1'b0, 1'b0, 6'd63},
    {1'b1, 1'b0, 4'd0,  4'd0,  1'b1, 1'b0, 6'd63},
    {1'b1, 1'b1, 4'd15, 4'd0,  1'b0, 1'b1, 6'd63},
    {1'b0, 1'b0, 4'd2,  4'd10, 1'b0, 1'b0, 6'd0},
    {1'b0, 1'b0, 4'd5,  4'd10, 1'b1, 1'b0, 6'd9},
    {1'b0, 1'b0, 4'd1,  4'd10, 1'b0, 1'b0, 6'd17},
    {1'b1, 1'b0, 4'd0,  4'd0,  1'b1, 1'b0, 6'd8},
    {1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 1'b0, 6'd14},
    {1'b0, 1'b0, 4'd4,  4'd5,  1'b0, 1'b0, 6'd63},
    {1'b0, 1'b0, 4'd5,  4'd5,  1'b0, 1'b0, 6'd63},
    {1'b0, 1'b0, 4'd12, 4'd15, 1'b0, 1'b0, 6'd63},
    {1'b0, 1'b0, 4'd7,  4'd10, 1'b1, 1'b0, 6'd63}
  };

  localparam int REGS [8] = '{'hCC, 'hBF, 'hAA, 'hAB, 'hCD, 'hAD, 'hAE, 'hAF};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void exp_step(input bit job, input int mode, input int idx,
                                   input int pg_in, input int ln_in,
                                   output int k, output int b, output int pg, output int ln);
    k = 0; b = 0; pg = 0; ln = 0;
    if (!job) begin
      if (idx == 0) b = 'h36;
      else if (idx == 17) b = 'h16;
      else if ((idx - 1) % 2 == 0) begin k = 1; b = REGS[(idx - 1) / 2]; end
      else begin k = 2; b = ((mode * 8 + (idx - 1) / 2) ^ 'hA5) & 'hFF; end
    end else begin
      case (idx)
        0:  k = 3;
        1:  b = 'h36;
        2:  begin k = 1; b = 'h38; end
        3:  begin k = 2; b = 'h52; end
        4:  b = 'h16;
        5:  b = 'h17;
        6:  b = 'h04;
        7:  b = 'h19;
        8:  begin k = 4; pg = pg_in; ln = ln_in; end
        9:  k = 3;
        10: b = 'h36;
        11: begin k = 1; b = 'h38; end
        12: begin k = 2; b = 'h00; end
        13: b = 'h16;
        default: k = 4;
      endcase
    end
  endfunction

  task automatic run_vec(input logic [17:0] v);
    bit job    = v[17];
    int pg     = v[16] ? 'h200 : 'h21F;
    int ln     = v[16] ? 528 : 784;
    int mode   = int'(v[15:12]);
    int cfg    = int'(v[11:8]);
    bit stall  = v[7];
    bit poke   = v[6];
    int fail_at = (v[5:0] == 6'd63) ? -1 : int'(v[5:0]);
    bit rej    = !job && (mode >= cfg || mode >= 10);
    int total  = job ? 15 : 18;
    int idx    = 0;
    bit tog    = 1'b0;
    bit prev_stall = 1'b0;
    int ek, eb, ep, el;
    string base;
    @(negedge clk);
    start = 1'b1; job_sel = job; mode_idx = 4'(mode); cfg_modes = 4'(cfg);
    otp_page = 24'(pg); otp_len = 16'(ln);
    @(negedge clk);
    start = 1'b0; mode_idx = 4'hF; otp_page = '1; otp_len = '1;
    if (rej) begin
      chk("R7 err pulse", int'(err), 1);
      chk("R7 no bus cycle", int'(bus_valid), 0);
      chk("R7 not busy", int'(busy), 0);
      return;
    end
    chk("R9 busy after start", int'(busy), 1);
    for (int it = 0; it < 200; it++) begin
      bit rdy, f;
      if (!bus_valid) break;
      exp_step(job, mode, idx, pg, ln, ek, eb, ep, el);
      if (prev_stall) base = "R6";
      else if (job) base = (idx < 9) ? "R3" : "R4";
      else base = (idx == 0 || idx == 17) ? "R1" : "R2";
      chk($sformatf("%s kind idx%0d", base, idx), int'(bus_kind), ek);
      chk($sformatf("%s byte idx%0d", base, idx), int'(bus_byte), eb);
      chk($sformatf("%s page idx%0d", base, idx), int'(bus_page), ep);
      chk($sformatf("%s len idx%0d", base, idx), int'(bus_len), el);
      rdy = !(stall && !tog);
      tog = !tog;
      f = rdy && (idx == fail_at);
      if (poke && idx == 2) begin start = 1'b1; job_sel = !job; end
      bus_ready = rdy; bus_fail = f;
      @(negedge clk);
      start = 1'b0; bus_ready = 1'b0; bus_fail = 1'b0;
      prev_stall = !rdy;
      if (rdy) begin
        idx++;
        if (f) break;
      end
    end
    if (fail_at >= 0) begin
      chk("R5 err pulse", int'(err), 1);
      chk("R5 done low", int'(done), 0);
      chk("R5 bus stopped", int'(bus_valid), 0);
      chk("R5 cycles issued", idx, fail_at + 1);
    end else begin
      chk("R9 done pulse", int'(done), 1);
      chk("R9 err low", int'(err), 0);
      chk("R9 busy low", int'(busy), 0);
      chk(poke ? "R8 cycles issued" : "R1 cycles issued", idx, total);
    end
    @(negedge clk);
    chk("R9 pulses one cycle", int'(done | err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset busy", int'(busy), 0);
    chk("R9 reset valid", int'(bus_valid), 0);
    chk("R9 reset done", int'(done), 0);
    chk("R5 reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // directed: reject for the table-read job must not happen even with mode above the limit (R7)
    @(negedge clk);
    start = 1'b1; job_sel = 1'b1; mode_idx = 4'd14; cfg_modes = 4'd0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 table job not rejected", int'(busy), 1);
    chk("R7 table job no err", int'(err), 0);
    // directed: reset while running clears the job (R9)
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset mid job busy", int'(busy), 0);
    chk("R9 reset mid job valid", int'(bus_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule